// File: doc/BRIEF.md
# Cascaded Interrupt Status Encoder

The block gathers interrupt requests from three nested source groups (critical, main and peripheral) and from a group of 32 DMA completion sources. A separate mask register covers each group. Every clock the block builds one 32-bit status word that holds a pending flag and the number of the winning source for each of the three top-level groups. It also drives one interrupt line to the CPU. The groups are cascaded. A peripheral group sits inside both the critical and the main group through one reserved source number in each. The DMA group sits inside the peripheral group at source 0. Software can therefore walk from the status word down to the exact leaf source.

A small register port, with write strobe, address, write data and combinational read data, gives access to the four mask registers and to the DMA pending register. DMA requests are sticky. Software clears them by writing ones. Within a group the lowest-numbered enabled pending source wins. The critical field is read first, then main, then peripheral.

Top module: `cascade_irq_encoder`

## Requirements
- R1: After reset, the four mask registers (addresses 0 to 3) read 0xFFFFFFFF, the DMA pending register (address 4) reads 0, `statusWord` is 0 and `cpuIrq` is low.
- R2: Critical group: status bit 10 is set when an enabled critical source is pending, and bits 9:8 hold the lowest such source number. Critical source n is disabled while bit (3-n) of the critical mask (address 0) is 1.
- R3: Main group: status bit 21 is the pending flag and bits 20:16 hold the lowest enabled pending main source (0 to 16). Main source n is disabled while bit (16-n) of the main mask (address 1) is 1.
- R4: Peripheral group: status bit 29 is the pending flag and bits 28:24 hold the lowest enabled pending peripheral source (0 to 31). Peripheral source n is disabled while bit (31-n) of the peripheral mask (address 2) is 1.
- R5: Critical source 2 is pending when any enabled peripheral source 0 to 3 is pending. Main source 4 is pending when any enabled peripheral source 4 to 31 is pending. The raw inputs `critReq[2]`, `mainReq[4]` and `periReq[0]` have no effect.
- R6: DMA pending bit n is set at a clock edge where `dmaReq[n]` is 1, and it stays set. A write to address 4 clears each pending bit whose data bit is 1. A request at the same edge keeps its bit set.
- R7: DMA source n is disabled while bit n of the DMA mask (address 3) is 1. Peripheral source 0 is pending when any enabled DMA pending bit is set.
- R8: `cpuIrq` equals the OR of status bits 10, 21 and 29 in every cycle.
- R9: `statusWord` and `cpuIrq` reflect request inputs one clock edge after they are applied. Status bits outside the three fields are 0, and an index field is 0 while its flag is clear.
- R10: `regRdata` shows the register at `regAddr` combinationally. Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| critReq | input | 4 | Raw critical requests (bit 2 unused, cascade slot) |
| mainReq | input | 17 | Raw main requests (bit 4 unused, cascade slot) |
| periReq | input | 32 | Raw peripheral requests (bit 0 unused, cascade slot) |
| dmaReq | input | 32 | DMA completion requests, latched as pending |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| statusWord | output | 32 | Encoded pending status |
| cpuIrq | output | 1 | Interrupt line to the CPU |

## Verification
Each group is driven with two or more pending sources, so the result shows whether the lowest number wins. A mask bit is then set on the winner to show that the count-down mask position is decoded correctly. Peripheral sources on both sides of the high/low split show which cascade slot lights up. Single raw requests on the cascade slots show that those inputs are ignored. A pulsed DMA request, followed by clears of a wrong bit, of the right bit, and of a bit whose request is still held, separates sticky set, write-one-to-clear and set-over-clear. A one-edge sampling check pins down the latency.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;

  typedef enum logic [2:0] {
    ADDR_CRIT_MASK = 3'd0,
    ADDR_MAIN_MASK = 3'd1,
    ADDR_PERI_MASK = 3'd2,
    ADDR_DMA_MASK  = 3'd3,
    ADDR_DMA_PEND  = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic wrCrit;
    logic wrMain;
    logic wrPeri;
    logic wrDmaMask;
    logic clrDmaPend;
  } regStrobe_t;

  localparam int STATUS_W      = 32;
  localparam int CRIT_FLAG_BIT = 10;
  localparam int CRIT_IDX_LSB  = 8;
  localparam int MAIN_FLAG_BIT = 21;
  localparam int MAIN_IDX_LSB  = 16;
  localparam int PERI_FLAG_BIT = 29;
  localparam int PERI_IDX_LSB  = 24;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // Lowest-numbered set bit wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/irq_enc_ctrl.sv
module irq_enc_ctrl
  import irq_enc_pkg::*;
(
  input  logic       regWe,
  input  logic [2:0] regAddr,
  output regStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (regWe) begin
      unique case (regAddr)
        ADDR_CRIT_MASK: strobe.wrCrit     = 1'b1;
        ADDR_MAIN_MASK: strobe.wrMain     = 1'b1;
        ADDR_PERI_MASK: strobe.wrPeri     = 1'b1;
        ADDR_DMA_MASK:  strobe.wrDmaMask  = 1'b1;
        ADDR_DMA_PEND:  strobe.clrDmaPend = 1'b1;
        default:        strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_enc_datapath.sv
module irq_enc_datapath
  import irq_enc_pkg::*;
#(
  parameter int CRIT_N    = 4,
  parameter int MAIN_N    = 17,
  parameter int PERI_N    = 32,
  parameter int DMA_N     = 32,
  parameter int REG_W     = 32,
  parameter int PERI_HI_N = 4,
  parameter int CRIT_CASC = 2,
  parameter int MAIN_CASC = 4,
  localparam int CRIT_IW  = $clog2(CRIT_N),
  localparam int MAIN_IW  = $clog2(MAIN_N),
  localparam int PERI_IW  = $clog2(PERI_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strobe,
  input  logic [REG_W-1:0]  wrData,
  input  logic [2:0]        rdAddr,
  input  logic [CRIT_N-1:0] critReq,
  input  logic [MAIN_N-1:0] mainReq,
  input  logic [PERI_N-1:0] periReq,
  input  logic [DMA_N-1:0]  dmaReq,
  output logic [REG_W-1:0]  rdData,
  output logic [STATUS_W-1:0] statusWord,
  output logic              cpuIrq
);
  logic [REG_W-1:0] critMask, mainMask, periMask;
  logic [DMA_N-1:0] dmaMask, dmaPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      critMask <= '1;
      mainMask <= '1;
      periMask <= '1;
      dmaMask  <= '1;
      dmaPend  <= '0;
    end else begin
      if (strobe.wrCrit)    critMask <= wrData;
      if (strobe.wrMain)    mainMask <= wrData;
      if (strobe.wrPeri)    periMask <= wrData;
      if (strobe.wrDmaMask) dmaMask  <= wrData[DMA_N-1:0];
      dmaPend <= (dmaPend & ~(strobe.clrDmaPend ? wrData[DMA_N-1:0] : '0)) | dmaReq;
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CRIT_MASK: rdData = critMask;
      ADDR_MAIN_MASK: rdData = mainMask;
      ADDR_PERI_MASK: rdData = periMask;
      ADDR_DMA_MASK:  rdData = REG_W'(dmaMask);
      ADDR_DMA_PEND:  rdData = REG_W'(dmaPend);
      default:        rdData = '0;
    endcase
  end

  // Cascade slots replace these raw inputs.
  logic unusedCascIn;
  assign unusedCascIn = ^{critReq[CRIT_CASC], mainReq[MAIN_CASC], periReq[0]};

  logic              dmaAny;
  logic [PERI_N-1:0] periEff;
  logic [CRIT_N-1:0] critEff;
  logic [MAIN_N-1:0] mainEff;
  logic              periHi, periLo;

  assign dmaAny = |(dmaPend & ~dmaMask);

  for (genvar g = 0; g < PERI_N; g++) begin : g_peri
    if (g == 0) begin : g_casc
      assign periEff[g] = dmaAny & ~periMask[REG_W-1-g];
    end else begin : g_raw
      assign periEff[g] = periReq[g] & ~periMask[REG_W-1-g];
    end
  end

  assign periHi = |periEff[PERI_HI_N-1:0];
  assign periLo = |periEff[PERI_N-1:PERI_HI_N];

  for (genvar g = 0; g < CRIT_N; g++) begin : g_crit
    if (g == CRIT_CASC) begin : g_casc
      assign critEff[g] = periHi & ~critMask[CRIT_N-1-g];
    end else begin : g_raw
      assign critEff[g] = critReq[g] & ~critMask[CRIT_N-1-g];
    end
  end

  for (genvar g = 0; g < MAIN_N; g++) begin : g_main
    if (g == MAIN_CASC) begin : g_casc
      assign mainEff[g] = periLo & ~mainMask[MAIN_N-1-g];
    end else begin : g_raw
      assign mainEff[g] = mainReq[g] & ~mainMask[MAIN_N-1-g];
    end
  end

  logic               critAny, mainAny, periAny;
  logic [CRIT_IW-1:0] critIdx;
  logic [MAIN_IW-1:0] mainIdx;
  logic [PERI_IW-1:0] periIdx;

  irq_prio_pick #(.N(CRIT_N)) u_critPick (.req(critEff), .any(critAny), .idx(critIdx));
  irq_prio_pick #(.N(MAIN_N)) u_mainPick (.req(mainEff), .any(mainAny), .idx(mainIdx));
  irq_prio_pick #(.N(PERI_N)) u_periPick (.req(periEff), .any(periAny), .idx(periIdx));

  logic [STATUS_W-1:0] statusNext;
  always_comb begin
    statusNext = '0;
    statusNext[CRIT_FLAG_BIT] = critAny;
    statusNext[MAIN_FLAG_BIT] = mainAny;
    statusNext[PERI_FLAG_BIT] = periAny;
    statusNext[CRIT_IDX_LSB +: CRIT_IW] = critIdx;
    statusNext[MAIN_IDX_LSB +: MAIN_IW] = mainIdx;
    statusNext[PERI_IDX_LSB +: PERI_IW] = periIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusWord <= '0;
      cpuIrq     <= 1'b0;
    end else begin
      statusWord <= statusNext;
      cpuIrq     <= critAny | mainAny | periAny;
    end
  end
endmodule

// File: rtl/cascade_irq_encoder.sv
module cascade_irq_encoder
  import irq_enc_pkg::*;
#(
  parameter int CRIT_N    = 4,
  parameter int MAIN_N    = 17,
  parameter int PERI_N    = 32,
  parameter int DMA_N     = 32,
  parameter int REG_W     = 32,
  parameter int PERI_HI_N = 4,
  parameter int CRIT_CASC = 2,
  parameter int MAIN_CASC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CRIT_N-1:0] critReq,
  input  logic [MAIN_N-1:0] mainReq,
  input  logic [PERI_N-1:0] periReq,
  input  logic [DMA_N-1:0]  dmaReq,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [STATUS_W-1:0] statusWord,
  output logic              cpuIrq
);
  regStrobe_t strobe;

  irq_enc_ctrl u_ctrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  irq_enc_datapath #(
    .CRIT_N(CRIT_N), .MAIN_N(MAIN_N), .PERI_N(PERI_N), .DMA_N(DMA_N),
    .REG_W(REG_W), .PERI_HI_N(PERI_HI_N), .CRIT_CASC(CRIT_CASC), .MAIN_CASC(MAIN_CASC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wrData    (regWdata),
    .rdAddr    (regAddr),
    .critReq   (critReq),
    .mainReq   (mainReq),
    .periReq   (periReq),
    .dmaReq    (dmaReq),
    .rdData    (regRdata),
    .statusWord(statusWord),
    .cpuIrq    (cpuIrq)
  );
endmodule

// File: rtl/irq_enc_checker.sv
module irq_enc_checker
  import irq_enc_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [STATUS_W-1:0] statusWord,
  input logic                cpuIrq
);
  logic [STATUS_W-1:0] fieldBits;
  always_comb begin
    fieldBits = '0;
    fieldBits[CRIT_FLAG_BIT] = 1'b1;
    fieldBits[CRIT_IDX_LSB +: 2] = '1;
    fieldBits[MAIN_FLAG_BIT] = 1'b1;
    fieldBits[MAIN_IDX_LSB +: 5] = '1;
    fieldBits[PERI_FLAG_BIT] = 1'b1;
    fieldBits[PERI_IDX_LSB +: 5] = '1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (statusWord == '0 && !cpuIrq));

  assert_irq_or_R8: assert property (@(posedge clk) disable iff (rst)
    cpuIrq == (statusWord[CRIT_FLAG_BIT] | statusWord[MAIN_FLAG_BIT] | statusWord[PERI_FLAG_BIT]));

  assert_idle_fields_R9: assert property (@(posedge clk) disable iff (rst)
    ((statusWord & ~fieldBits) == '0)
    && (statusWord[CRIT_FLAG_BIT] || statusWord[CRIT_IDX_LSB +: 2] == '0)
    && (statusWord[MAIN_FLAG_BIT] || statusWord[MAIN_IDX_LSB +: 5] == '0)
    && (statusWord[PERI_FLAG_BIT] || statusWord[PERI_IDX_LSB +: 5] == '0));

  assert_crit_casc_R5: assert property (@(posedge clk) disable iff (rst)
    (statusWord[CRIT_FLAG_BIT] && statusWord[CRIT_IDX_LSB +: 2] == 2'd2) |-> statusWord[PERI_FLAG_BIT]);

  assert_main_casc_R5: assert property (@(posedge clk) disable iff (rst)
    (statusWord[MAIN_FLAG_BIT] && statusWord[MAIN_IDX_LSB +: 5] == 5'd4) |-> statusWord[PERI_FLAG_BIT]);
endmodule

bind cascade_irq_encoder irq_enc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .statusWord(statusWord),
  .cpuIrq    (cpuIrq)
);

// File: tb/tb_cascade_irq_encoder.sv
module tb_cascade_irq_encoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [31:0] periReq = '0;
  logic [31:0] dmaReq = '0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] statusWord;
  logic        cpuIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_encoder dut (
    .clk(clk), .rst(rst), .critReq(critReq), .mainReq(mainReq), .periReq(periReq),
    .dmaReq(dmaReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .statusWord(statusWord), .cpuIrq(cpuIrq)
  );

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic checkStatus(input logic [31:0] exp, input string what);
    check32(statusWord, exp, what);
    check32({31'b0, cpuIrq}, {31'b0, exp[10] | exp[21] | exp[29]}, {what, " R8 cpuIrq"});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cleanSlate();
    @(negedge clk);
    critReq = '0; mainReq = '0; periReq = '0; dmaReq = '0;
    for (int a = 0; a < 4; a++) wr(3'(a), 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic testReset();
    logic [31:0] v;
    checkStatus(32'h0, "R1 status after reset");
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check32(v, 32'hFFFF_FFFF, "R1 mask reset value");
    end
    rd(3'd4, v);
    check32(v, 32'h0, "R1 DMA pending reset value");
  endtask

  task automatic testAllMasked();
    logic [31:0] v;
    cleanSlate();
    critReq = '1; mainReq = '1; periReq = '1; dmaReq = '1;
    settle();
    checkStatus(32'h0, "R2 R3 R4 all sources masked");
    rd(3'd4, v);
    check32(v, 32'hFFFF_FFFF, "R6 pending latched while masked");
    critReq = '0; mainReq = '0; periReq = '0; dmaReq = '0;
  endtask

  task automatic testCritical();
    cleanSlate();
    wr(3'd0, 32'h0);
    critReq = 4'b1010;
    settle();
    checkStatus(32'h0000_0500, "R2 lowest critical wins");
    wr(3'd0, 32'h1 << (3 - 1));
    settle();
    checkStatus(32'h0000_0700, "R2 critical source 1 masked");
    wr(3'd0, 32'h0);
    critReq = 4'b0100;
    settle();
    checkStatus(32'h0, "R5 raw critical slot ignored");
  endtask

  task automatic testMain();
    cleanSlate();
    wr(3'd1, 32'h0);
    mainReq = (17'h1 << 16) | (17'h1 << 7);
    settle();
    checkStatus(32'h0027_0000, "R3 lowest main wins");
    wr(3'd1, 32'h1 << (16 - 7));
    settle();
    checkStatus(32'h0030_0000, "R3 main source 7 masked");
    wr(3'd1, 32'h0);
    mainReq = 17'h1 << 4;
    settle();
    checkStatus(32'h0, "R5 raw main slot ignored");
  endtask

  task automatic testPeripheral();
    cleanSlate();
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, 32'h0);
    periReq = (32'h1 << 31) | (32'h1 << 5);
    settle();
    checkStatus(32'h2524_0000, "R4 R5 low peripheral via main slot 4");
    periReq = 32'h1;
    settle();
    checkStatus(32'h0, "R5 raw peripheral slot 0 ignored");
    periReq = 32'h1 << 3;
    settle();
    checkStatus(32'h2300_0600, "R5 high peripheral via critical slot 2");
    wr(3'd2, 32'h1 << (31 - 3));
    settle();
    checkStatus(32'h0, "R4 peripheral source 3 masked");
    periReq = '0;
  endtask

  task automatic testDma();
    logic [31:0] v;
    cleanSlate();
    for (int a = 0; a < 4; a++) wr(3'(a), 32'h0);
    @(negedge clk);
    dmaReq = 32'h1 << 9;
    @(negedge clk);
    dmaReq = '0;
    settle();
    rd(3'd4, v);
    check32(v, 32'h0000_0200, "R6 pending bit sticky after pulse");
    checkStatus(32'h2000_0600, "R7 DMA cascades to peripheral 0");
    wr(3'd4, 32'h0000_0100);
    rd(3'd4, v);
    check32(v, 32'h0000_0200, "R6 clear of other bit has no effect");
    wr(3'd4, 32'h0000_0200);
    rd(3'd4, v);
    check32(v, 32'h0, "R6 write one clears");
    settle();
    checkStatus(32'h0, "R7 status idle after clear");
    @(negedge clk);
    dmaReq = 32'h1 << 9;
    wr(3'd4, 32'h0000_0200);
    rd(3'd4, v);
    check32(v, 32'h0000_0200, "R6 request beats clear");
    dmaReq = '0;
    wr(3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic testDmaMask();
    logic [31:0] v;
    cleanSlate();
    for (int a = 0; a < 3; a++) wr(3'(a), 32'h0);
    wr(3'd3, 32'h1 << 9);
    @(negedge clk);
    dmaReq = 32'h1 << 9;
    @(negedge clk);
    dmaReq = '0;
    settle();
    rd(3'd4, v);
    check32(v, 32'h0000_0200, "R7 masked DMA still pending");
    checkStatus(32'h0, "R7 masked DMA does not cascade");
    wr(3'd3, 32'h0);
    settle();
    checkStatus(32'h2000_0600, "R7 unmasking exposes DMA");
  endtask

  task automatic testLatency();
    cleanSlate();
    wr(3'd0, 32'h0);
    @(negedge clk);
    critReq = 4'b0001;
    #1;
    checkStatus(32'h0, "R9 no change before edge");
    @(negedge clk);
    checkStatus(32'h0000_0400, "R9 status one edge later");
    critReq = '0;
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    cleanSlate();
    for (int a = 5; a < 8; a++) wr(3'(a), 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check32(v, 32'hFFFF_FFFF, "R10 unused address write ignored");
    end
    rd(3'd6, v);
    check32(v, 32'h0, "R10 unused address reads zero");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testAllMasked();
    testCritical();
    testMain();
    testPeripheral();
    testDma();
    testDmaMask();
    testLatency();
    testRegMap();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule